// File: doc/BRIEF.md
# Dual-Buffer Receive DMA Engine

This block takes bytes from a serial receiver's output and writes them into memory through a byte-wide write port. It fills two buffers, A and B, in turn. Each buffer has its own start address and length, and software arms a buffer by pulsing its strobe. While one buffer fills, software can re-arm the other one, so reception carries on across buffers without losing a byte. Each buffer has its own status: an active bit, a parity-error flag and a framing-error flag. One shared flag reports a byte that arrived when no buffer could take it.

When the block serves an SPI slave receiver, it watches for chip-select deassertion pulses. On each pulse it stores the byte count of the buffer in use. It also keeps a 3-bit code that names that buffer and tells whether more than one deassertion has been seen. A synchronous DMA reset input returns all transfer state to idle in one clock.

Top module: `rxdma_pingpong`

## Requirements
- R1: Pulsing `arm_a` or `arm_b` latches that buffer's base and length and sets its active bit on the next clock. The bit stays set until the buffer has received `len` bytes, then clears. A length of 0 stands for 2^LEN_W bytes.
- R2: When both buffers are active and neither is part-filled, the next byte goes to buffer A.
- R3: A byte with `rx_valid` high goes to the buffer being filled, at address base plus the number of bytes already in that buffer. `mem_we`, `mem_addr` and `mem_wdata` show the write one clock later. The byte after a full buffer goes to the other buffer if that buffer is active, even if the bytes come on back-to-back clocks.
- R4: A byte that arrives while neither buffer is active is dropped with no memory write, and `ovf` sets. `ovf` stays set until DMA reset.
- R5: In UART mode (`uart_mode`=1), a byte with `rx_par_err` sets the parity flag of the buffer it went into. Only re-arming that buffer or a DMA reset clears the flag.
- R6: In UART mode, a byte with `rx_frm_err` sets the framing flag of its buffer. The flag clears under the same rules as in R5.
- R7: In SPI mode (`uart_mode`=0), the parity and framing flags never set.
- R8: In SPI mode, a `ss_deassert` pulse while some buffer is active updates `ss_stat`:
  - bit 0 names the buffer in use (0 = A, 1 = B). If no buffer is part-filled, it names the buffer that would take the next byte.
  - bit 1 = 1.
  - bit 2 = 1 if bit 1 was already set.
  - The resulting codes are 0, 2, 3, 6 and 7; codes 1, 4 and 5 never occur.
  - In UART mode the pulse has no effect.
- R9: On the same pulse, `saved_cnt` takes the number of bytes written so far into the buffer in use. A byte arriving in the same cycle is not included.
- R10: Arming either buffer clears `ss_stat` to 0. Arming wins over a deassertion pulse in the same cycle.
- R11: `dma_rst` clears the active bits, the byte count, all flags, `ss_stat` and `saved_cnt` on the next clock, and overrides every other input in that cycle.
- R12: After `rst_n` is asserted, every status output and `mem_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_rst | input | 1 | Synchronous receive DMA reset |
| uart_mode | input | 1 | 1 = UART (error capture), 0 = SPI slave |
| arm_a | input | 1 | Arm strobe for buffer A |
| arm_b | input | 1 | Arm strobe for buffer B |
| base_a | input | ADDR_W | Start address of buffer A |
| len_a | input | LEN_W | Byte length of buffer A |
| base_b | input | ADDR_W | Start address of buffer B |
| len_b | input | LEN_W | Byte length of buffer B |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| rx_par_err | input | 1 | Byte has parity error |
| rx_frm_err | input | 1 | Byte has framing error |
| ss_deassert | input | 1 | Chip-select deassertion pulse |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| act_a | output | 1 | Buffer A active or pending |
| act_b | output | 1 | Buffer B active or pending |
| ovf | output | 1 | Byte dropped, no buffer active |
| par_a | output | 1 | Parity error in buffer A |
| par_b | output | 1 | Parity error in buffer B |
| frm_a | output | 1 | Framing error in buffer A |
| frm_b | output | 1 | Framing error in buffer B |
| ss_stat | output | 3 | Saved-count status code |
| saved_cnt | output | LEN_W | Byte count captured on deassertion |

## Verification
The bench streams bytes back-to-back across the point where buffer A fills. A design that drops or repeats the boundary byte shows a missing or extra write, or a wrong address, in the scoreboard.

It re-arms A while B is part-filled. A design that gives A priority at that point breaks the fill order and jumps back to A too early.

Error bytes go into each buffer in turn, and the bench then re-arms only one of them. A design with shared flags, or one that clears both flags, is caught there. The same bytes are also sent in SPI mode, where no flag may set.

The deassertion sequence walks the codes 2, 6, 0, 3 and 7 and checks the saved counts. A design that leaves out the repeat bit, reads the count after the current byte, or ignores the clear on arm gives the wrong code or count.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
    typedef enum logic [1:0] {
        FILL_NONE = 2'd0,
        FILL_A    = 2'd1,
        FILL_B    = 2'd2
    } fill_e;
endpackage

// File: rtl/rxdma_pick.sv
// Chooses the buffer that takes the next byte: the one in progress, else A, else B.
module rxdma_pick
    import rxdma_pkg::*;
(
    input  fill_e fill,
    input  logic  act_a,
    input  logic  act_b,
    output fill_e tgt
);
    always_comb begin
        if (fill != FILL_NONE) tgt = fill;
        else if (act_a)        tgt = FILL_A;
        else if (act_b)        tgt = FILL_B;
        else                   tgt = FILL_NONE;
    end
endmodule

// File: rtl/rxdma_sscode.sv
// Next saved-count status code: bit0 buffer, bit1 saved, bit2 repeated.
module rxdma_sscode (
    input  logic [2:0] cur,
    input  logic       is_b,
    output logic [2:0] nxt
);
    always_comb nxt = {cur[1], 1'b1, is_b};
endmodule

// File: rtl/rxdma_pingpong.sv
module rxdma_pingpong
    import rxdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_rst,
    input  logic              uart_mode,
    input  logic              arm_a,
    input  logic              arm_b,
    input  logic [ADDR_W-1:0] base_a,
    input  logic [LEN_W-1:0]  len_a,
    input  logic [ADDR_W-1:0] base_b,
    input  logic [LEN_W-1:0]  len_b,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_par_err,
    input  logic              rx_frm_err,
    input  logic              ss_deassert,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              act_a,
    output logic              act_b,
    output logic              ovf,
    output logic              par_a,
    output logic              par_b,
    output logic              frm_a,
    output logic              frm_b,
    output logic [2:0]        ss_stat,
    output logic [LEN_W-1:0]  saved_cnt
);
    typedef struct packed {
        logic              act_a;
        logic              act_b;
        fill_e             fill;
        logic [LEN_W-1:0]  cnt;
        logic [ADDR_W-1:0] base_a;
        logic [ADDR_W-1:0] base_b;
        logic [LEN_W-1:0]  len_a;
        logic [LEN_W-1:0]  len_b;
        logic              ovf;
        logic              par_a;
        logic              par_b;
        logic              frm_a;
        logic              frm_b;
        logic [2:0]        stat;
        logic [LEN_W-1:0]  scnt;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } state_t;

    state_t q, d;

    // Arm stage: re-arming the buffer in progress restarts its count.
    logic             armed_act_a, armed_act_b, restart;
    fill_e            armed_fill;
    logic [LEN_W-1:0] armed_cnt;

    assign armed_act_a = q.act_a | arm_a;
    assign armed_act_b = q.act_b | arm_b;
    assign restart     = (arm_a && q.fill == FILL_A) || (arm_b && q.fill == FILL_B);
    assign armed_fill  = restart ? FILL_NONE : q.fill;
    assign armed_cnt   = restart ? '0 : q.cnt;

    fill_e      ss_tgt, rx_tgt;
    logic [2:0] ss_next;

    rxdma_pick u_pick_ss (
        .fill (q.fill),
        .act_a(q.act_a),
        .act_b(q.act_b),
        .tgt  (ss_tgt)
    );

    rxdma_pick u_pick_rx (
        .fill (armed_fill),
        .act_a(armed_act_a),
        .act_b(armed_act_b),
        .tgt  (rx_tgt)
    );

    rxdma_sscode u_sscode (
        .cur (q.stat),
        .is_b(ss_tgt == FILL_B),
        .nxt (ss_next)
    );

    logic [LEN_W-1:0]  cnt_inc;
    logic [LEN_W-1:0]  tgt_len;
    logic [ADDR_W-1:0] tgt_base;

    always_comb begin
        d         = q;
        d.we      = 1'b0;
        d.fill    = armed_fill;
        d.cnt     = armed_cnt;
        cnt_inc   = armed_cnt + 1'b1;
        tgt_len   = '0;
        tgt_base  = '0;

        // chip-select deassertion: sampled on pre-byte state
        if (ss_deassert && !uart_mode && ss_tgt != FILL_NONE) begin
            d.stat = ss_next;
            d.scnt = q.cnt;
        end

        if (arm_a) begin
            d.act_a  = 1'b1;
            d.base_a = base_a;
            d.len_a  = len_a;
            d.par_a  = 1'b0;
            d.frm_a  = 1'b0;
            d.stat   = '0;
            d.scnt   = q.scnt;
        end
        if (arm_b) begin
            d.act_b  = 1'b1;
            d.base_b = base_b;
            d.len_b  = len_b;
            d.par_b  = 1'b0;
            d.frm_b  = 1'b0;
            d.stat   = '0;
            d.scnt   = q.scnt;
        end

        if (rx_valid) begin
            if (rx_tgt == FILL_NONE) begin
                d.ovf = 1'b1;
            end else begin
                tgt_base = (rx_tgt == FILL_A) ? d.base_a : d.base_b;
                tgt_len  = (rx_tgt == FILL_A) ? d.len_a  : d.len_b;
                d.we     = 1'b1;
                d.addr   = tgt_base + ADDR_W'(armed_cnt);
                d.data   = rx_data;
                if (uart_mode) begin
                    if (rx_tgt == FILL_A) begin
                        d.par_a = d.par_a | rx_par_err;
                        d.frm_a = d.frm_a | rx_frm_err;
                    end else begin
                        d.par_b = d.par_b | rx_par_err;
                        d.frm_b = d.frm_b | rx_frm_err;
                    end
                end
                if (cnt_inc == tgt_len) begin
                    if (rx_tgt == FILL_A) d.act_a = 1'b0;
                    else                  d.act_b = 1'b0;
                    d.fill = FILL_NONE;
                    d.cnt  = '0;
                end else begin
                    d.fill = rx_tgt;
                    d.cnt  = cnt_inc;
                end
            end
        end

        if (dma_rst) begin
            d.act_a = 1'b0;
            d.act_b = 1'b0;
            d.fill  = FILL_NONE;
            d.cnt   = '0;
            d.ovf   = 1'b0;
            d.par_a = 1'b0;
            d.par_b = 1'b0;
            d.frm_a = 1'b0;
            d.frm_b = 1'b0;
            d.stat  = '0;
            d.scnt  = '0;
            d.we    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_we    = q.we;
    assign mem_addr  = q.addr;
    assign mem_wdata = q.data;
    assign act_a     = q.act_a;
    assign act_b     = q.act_b;
    assign ovf       = q.ovf;
    assign par_a     = q.par_a;
    assign par_b     = q.par_b;
    assign frm_a     = q.frm_a;
    assign frm_b     = q.frm_b;
    assign ss_stat   = q.stat;
    assign saved_cnt = q.scnt;
endmodule

// File: rtl/rxdma_pingpong_chk.sv
module rxdma_pingpong_chk #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dma_rst,
    input logic              uart_mode,
    input logic              arm_a,
    input logic              arm_b,
    input logic [ADDR_W-1:0] base_a,
    input logic [LEN_W-1:0]  len_a,
    input logic [ADDR_W-1:0] base_b,
    input logic [LEN_W-1:0]  len_b,
    input logic              rx_valid,
    input logic [7:0]        rx_data,
    input logic              rx_par_err,
    input logic              rx_frm_err,
    input logic              ss_deassert,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              act_a,
    input logic              act_b,
    input logic              ovf,
    input logic              par_a,
    input logic              par_b,
    input logic              frm_a,
    input logic              frm_b,
    input logic [2:0]        ss_stat,
    input logic [LEN_W-1:0]  saved_cnt
);
    assert_arm_sets_act_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_a && !dma_rst) |=> act_a);

    assert_write_after_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(rx_valid));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !act_a && !act_b && !arm_a && !arm_b && !dma_rst) |=> (ovf && !mem_we));

    assert_frame_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(frm_a) || $rose(frm_b)) |-> $past(rx_frm_err));

    assert_spi_no_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(par_a) || $rose(par_b) || $rose(frm_a) || $rose(frm_b)) |-> $past(uart_mode));

    assert_code_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_stat != 3'd1 && ss_stat != 3'd4 && ss_stat != 3'd5));

    assert_arm_clears_stat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_a || arm_b) |=> (ss_stat == 3'd0));

    assert_dma_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rst |=> (!act_a && !act_b && !ovf && ss_stat == 3'd0 && !mem_we && saved_cnt == '0));
endmodule

bind rxdma_pingpong rxdma_pingpong_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/rxdma_pingpong_bench.sv
module rxdma_pingpong_bench;
    localparam int ADDR_W = 16;
    localparam int LEN_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              dma_rst = 1'b0, uart_mode = 1'b1;
    logic              arm_a = 1'b0, arm_b = 1'b0;
    logic [ADDR_W-1:0] base_a = '0, base_b = '0;
    logic [LEN_W-1:0]  len_a = '0, len_b = '0;
    logic              rx_valid = 1'b0, rx_par_err = 1'b0, rx_frm_err = 1'b0;
    logic [7:0]        rx_data = '0;
    logic              ss_deassert = 1'b0;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic              act_a, act_b, ovf, par_a, par_b, frm_a, frm_b;
    logic [2:0]        ss_stat;
    logic [LEN_W-1:0]  saved_cnt;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [23:0] expq[$];

    always #10 clk = ~clk;

    rxdma_pingpong #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_rxdma_pingpong (.*);

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // driver: one byte, pushes the expected memory write into the scoreboard
    task automatic send(logic [7:0] data, logic pe, logic fe, bit exp_wr, logic [15:0] addr);
        rx_valid = 1'b1; rx_data = data; rx_par_err = pe; rx_frm_err = fe;
        if (exp_wr) expq.push_back({addr, data});
        @(negedge clk);
        rx_valid = 1'b0; rx_par_err = 1'b0; rx_frm_err = 1'b0;
    endtask

    task automatic arm(bit a, bit b);
        arm_a = a; arm_b = b;
        @(negedge clk);
        arm_a = 1'b0; arm_b = 1'b0;
    endtask

    task automatic pulse_ss();
        ss_deassert = 1'b1;
        @(negedge clk);
        ss_deassert = 1'b0;
    endtask

    task automatic pulse_rst();
        dma_rst = 1'b1;
        @(negedge clk);
        dma_rst = 1'b0;
    endtask

    // monitor: pops the scoreboard on every memory write
    always @(negedge clk) begin
        if (rst_n && mem_we && !done) begin
            total++;
            if (expq.size() == 0) begin
                bad++;
                $display("FAIL R3/R4 unexpected write got=%0h exp=none", {mem_addr, mem_wdata});
            end else begin
                logic [23:0] e;
                e = expq.pop_front();
                if ({mem_addr, mem_wdata} !== e) begin
                    bad++;
                    $display("FAIL R3 write got=%0h exp=%0h", {mem_addr, mem_wdata}, e);
                end
            end
        end
    end

    initial begin
        int cyc = 0;
        while (cyc < 100000 && !done) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 act", {act_a, act_b, ovf, mem_we}, 0);
        check("R12 stat", ss_stat, 0);

        // R1 R2 R3: both armed, A first, seamless hand-over to B
        base_a = 16'h0100; len_a = 8'd3; base_b = 16'h0200; len_b = 8'd2;
        arm(1, 1);
        check("R1 both active", {act_a, act_b}, 2'b11);
        send(8'h11, 0, 0, 1, 16'h0100);
        send(8'h12, 0, 0, 1, 16'h0101);
        send(8'h13, 0, 0, 1, 16'h0102);
        check("R1 A done", {act_a, act_b}, 2'b01);
        send(8'h21, 0, 0, 1, 16'h0200);
        send(8'h22, 0, 0, 1, 16'h0201);
        check("R1 B done", {act_a, act_b}, 2'b00);

        // R4 overflow
        send(8'h99, 0, 0, 0, 16'h0);
        @(negedge clk);
        check("R4 ovf set", ovf, 1);
        check("R4 ovf held", {act_a, act_b}, 0);
        pulse_rst();
        check("R11 ovf cleared", ovf, 0);

        // R5 R6: per-buffer error flags in UART mode
        base_a = 16'h0300; len_a = 8'd2; base_b = 16'h0400; len_b = 8'd2;
        arm(1, 1);
        send(8'h31, 1, 0, 1, 16'h0300);
        check("R5 par_a", {par_a, par_b, frm_a, frm_b}, 4'b1000);
        send(8'h32, 0, 0, 1, 16'h0301);
        send(8'h41, 0, 1, 1, 16'h0400);
        check("R6 frm_b", {par_a, par_b, frm_a, frm_b}, 4'b1001);
        arm(1, 0);
        check("R5 re-arm A clears only A", {par_a, par_b, frm_a, frm_b}, 4'b0001);
        // R3 B still in progress keeps the next byte, then A
        send(8'h42, 0, 0, 1, 16'h0401);
        send(8'h33, 0, 0, 1, 16'h0300);
        check("R3 order after re-arm", {act_a, act_b}, 2'b10);
        pulse_rst();
        check("R11 clears", {act_a, act_b, par_a, par_b, frm_a, frm_b}, 0);

        // R7 SPI mode ignores error inputs
        uart_mode = 1'b0;
        base_a = 16'h0500; len_a = 8'd4; base_b = 16'h0600; len_b = 8'd2;
        arm(1, 0);
        send(8'h51, 1, 1, 1, 16'h0500);
        check("R7 no flags", {par_a, par_b, frm_a, frm_b}, 0);
        check("R8 nothing saved", ss_stat, 0);

        // R8 R9 R10 saved-count codes
        pulse_ss();
        check("R8 code A once", ss_stat, 3'd2);
        check("R9 count", saved_cnt, 1);
        send(8'h52, 0, 0, 1, 16'h0501);
        pulse_ss();
        check("R8 code A repeat", ss_stat, 3'd6);
        check("R9 count 2", saved_cnt, 2);
        arm(0, 1);
        check("R10 arm clears", ss_stat, 3'd0);
        send(8'h53, 0, 0, 1, 16'h0502);
        send(8'h54, 0, 0, 1, 16'h0503);
        send(8'h61, 0, 0, 1, 16'h0600);
        ss_deassert = 1'b1;
        send(8'h62, 0, 0, 1, 16'h0601);
        ss_deassert = 1'b0;
        check("R8 code B once", ss_stat, 3'd3);
        check("R9 count excludes same-cycle byte", saved_cnt, 1);
        base_b = 16'h0700; len_b = 8'd2;
        arm(0, 1);
        pulse_ss();
        pulse_ss();
        check("R8 code B repeat", ss_stat, 3'd7);
        ss_deassert = 1'b1; arm_a = 1'b1;
        @(negedge clk);
        ss_deassert = 1'b0; arm_a = 1'b0;
        check("R10 arm wins", ss_stat, 3'd0);
        pulse_ss();
        pulse_rst();
        check("R11 stat cleared", {ss_stat, saved_cnt}, 0);

        // R8 UART mode ignores the pulse
        uart_mode = 1'b1;
        arm(1, 0);
        pulse_ss();
        check("R8 uart ignore", ss_stat, 0);

        // R11 priority over arm
        dma_rst = 1'b1; arm_b = 1'b1;
        @(negedge clk);
        dma_rst = 1'b0; arm_b = 1'b0;
        check("R11 priority", {act_a, act_b}, 0);

        repeat (2) @(negedge clk);
        check("R3 scoreboard drained", expq.size(), 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule